// File: doc/BRIEF.md
# Video Capture Gate and Word Packer

This block sits between a 16-bit synchronous video decoder output and two banks of 16-bit-wide FIFO storage that together form 32-bit words. The decoder supplies a pixel-rate data bus and three qualifiers: a data-valid level that marks active samples, a vertical reference pulse, and a field indicator.

After reset, capture stays off until the vertical reference is seen together with the field value that marks the first field. From then on, only samples presented while data-valid is high are written, so blanking never reaches storage. A half-select toggle steers successive qualified samples to the low-half strobe and then to the high-half strobe. The same data bus is presented to both banks. The toggle restarts on the low half at every line start. A line with an odd number of samples is closed at its data-valid falling edge by writing a pad word into the high half, and that write is flagged.

A host can request a software reset. This clears the arming latch and the toggle, and drives a reset to the downstream FIFOs. The arming state is visible on an enable status output.

Top module: `vid_capture_packer`

## Requirements
- R1: While `rst_ni` is low, `fifo_rst_o` is 1 and `capture_en_o`, `wr_lo_o`, `wr_hi_o` and `pad_o` are 0. A cycle with `sw_rst_i` high makes `fifo_rst_o` 1 and all strobes and `capture_en_o` 0 in the following cycle, and capture stays disarmed afterwards until re-armed.
- R2: `capture_en_o` becomes 1 in the cycle after a cycle with `vref_i` high and `field_i` equal to `FIRST_FIELD`. `vref_i` with the other field value does not arm.
- R3: No strobe is raised for samples presented while disarmed or while `dv_i` is low (blanking). The only exception is the pad write of R7.
- R4: Once armed, each sample presented with `dv_i` high produces exactly one strobe in the next cycle, with `wr_data_o` equal to that sample. Strobes alternate low, high, low, ..., starting with `wr_lo_o`.
- R5: The first qualified sample after every `dv_i` rising edge goes to `wr_lo_o`. The next line therefore starts on a word boundary, whatever the parity of the previous line.
- R6: Once armed, `capture_en_o` stays 1 until a reset, whatever `vref_i` and `field_i` do.
- R7: When `dv_i` falls after an odd number of samples in an armed line, the next cycle has `wr_hi_o`=1, `pad_o`=1 and `wr_data_o`=`PAD_WORD`. After an even count no pad write occurs.
- R8: `wr_lo_o` and `wr_hi_o` are never high together, and `pad_o` is high only together with `wr_hi_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_rst_i | input | 1 | Synchronous host software reset |
| vid_data_i | input | DATA_W | Decoder sample bus |
| dv_i | input | 1 | Active-video data valid |
| vref_i | input | 1 | Vertical reference |
| field_i | input | 1 | Field indicator |
| wr_data_o | output | DATA_W | Data presented to both FIFO banks |
| wr_lo_o | output | 1 | Write strobe, low-half bank |
| wr_hi_o | output | 1 | Write strobe, high-half bank |
| pad_o | output | 1 | Current high-half write is a pad word |
| capture_en_o | output | 1 | Capture armed status |
| fifo_rst_o | output | 1 | Reset to downstream FIFOs |

## Verification
The bench builds the block with DATA_W=16, FIRST_FIELD=0 and PAD_WORD=16'h8010, the same widths the decoder and FIFO banks use. Line lengths are swept from 1 to 12 samples, which covers both parities repeatedly. This exercises the pad path, the toggle restart after odd and even lines, and back-to-back lines with a one-cycle gap. Arming is probed with the wrong field value and with active lines presented before arming. Later vertical pulses are applied after arming, and a software reset is issued in mid-line.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/vcp_frame_arm.sv
module vcp_frame_arm #(
  parameter logic FIRST_FIELD = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_rst_i,
  input  logic vref_i,
  input  logic field_i,
  output logic armed_o
);
  logic armed_q;
  logic frame_start;

  assign frame_start = vref_i && (field_i == FIRST_FIELD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          armed_q <= 1'b0;
    else if (sw_rst_i)    armed_q <= 1'b0;
    else if (frame_start) armed_q <= 1'b1;
  end

  assign armed_o = armed_q;

  // R6: sticky once set
  a_r6_stays_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !sw_rst_i |=> armed_q);

  // R2: only a first-field vertical reference arms
  a_r2_arm_needs_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q && !(vref_i && field_i == FIRST_FIELD) |=> !armed_q);
endmodule

// File: rtl/vcp_line_track.sv
module vcp_line_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_rst_i,
  input  logic dv_i,
  output logic dv_rise_o,
  output logic dv_fall_o
);
  logic dv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dv_q <= 1'b0;
    else if (sw_rst_i) dv_q <= 1'b0;
    else               dv_q <= dv_i;
  end

  assign dv_rise_o = dv_i && !dv_q;
  assign dv_fall_o = !dv_i && dv_q;
endmodule

// File: rtl/vcp_half_steer.sv
module vcp_half_steer
  import vcp_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter logic [DATA_W-1:0] PAD_WORD = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_rst_i,
  input  logic              dv_i,
  input  logic              armed_i,
  input  logic              dv_rise_i,
  input  logic              dv_fall_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_lo_o,
  output logic              wr_hi_o,
  output logic              pad_o,
  output logic [DATA_W-1:0] wr_data_o
);
  half_e             half_q, sel_now;
  logic              qual, do_pad;
  logic              wr_lo_q, wr_hi_q, pad_q;
  logic [DATA_W-1:0] data_q;

  assign qual    = dv_i && armed_i;
  assign sel_now = dv_rise_i ? HALF_LO : half_q;
  assign do_pad  = dv_fall_i && armed_i && (half_q == HALF_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= HALF_LO;
      wr_lo_q <= 1'b0;
      wr_hi_q <= 1'b0;
      pad_q   <= 1'b0;
      data_q  <= '0;
    end else if (sw_rst_i) begin
      half_q  <= HALF_LO;
      wr_lo_q <= 1'b0;
      wr_hi_q <= 1'b0;
      pad_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      wr_lo_q <= qual && (sel_now == HALF_LO);
      wr_hi_q <= (qual && (sel_now == HALF_HI)) || do_pad;
      pad_q   <= do_pad;
      if (qual)        data_q <= data_i;
      else if (do_pad) data_q <= PAD_WORD;
      if (qual)                        half_q <= (sel_now == HALF_LO) ? HALF_HI : HALF_LO;
      else if (dv_fall_i || dv_rise_i) half_q <= HALF_LO;
    end
  end

  assign wr_lo_o   = wr_lo_q;
  assign wr_hi_o   = wr_hi_q;
  assign pad_o     = pad_q;
  assign wr_data_o = data_q;

  // R5: every armed line opens on the low half
  a_r5_line_starts_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dv_rise_i && armed_i && !sw_rst_i |=> wr_lo_o);

  // R7: pad write closes an odd line
  a_r7_pad_on_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_o && !dv_i && armed_i && !sw_rst_i |=> wr_hi_o && pad_o);

  // R8: pad flag only rides on a high-half write
  a_r8_pad_with_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_o |-> wr_hi_o);
endmodule

// File: rtl/vid_capture_packer.sv
module vid_capture_packer #(
  parameter int unsigned       DATA_W      = 16,
  parameter logic              FIRST_FIELD = 1'b0,
  parameter logic [DATA_W-1:0] PAD_WORD    = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_rst_i,
  input  logic [DATA_W-1:0] vid_data_i,
  input  logic              dv_i,
  input  logic              vref_i,
  input  logic              field_i,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_lo_o,
  output logic              wr_hi_o,
  output logic              pad_o,
  output logic              capture_en_o,
  output logic              fifo_rst_o
);
  logic armed, dv_rise, dv_fall;
  logic fifo_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fifo_rst_q <= 1'b1;
    else         fifo_rst_q <= sw_rst_i;
  end
  assign fifo_rst_o = fifo_rst_q;

  vcp_frame_arm #(.FIRST_FIELD(FIRST_FIELD)) u_arm (
    .clk_i, .rst_ni, .sw_rst_i, .vref_i, .field_i, .armed_o(armed)
  );

  vcp_line_track u_line (
    .clk_i, .rst_ni, .sw_rst_i, .dv_i, .dv_rise_o(dv_rise), .dv_fall_o(dv_fall)
  );

  vcp_half_steer #(.DATA_W(DATA_W), .PAD_WORD(PAD_WORD)) u_steer (
    .clk_i, .rst_ni, .sw_rst_i, .dv_i,
    .armed_i  (armed),
    .dv_rise_i(dv_rise),
    .dv_fall_i(dv_fall),
    .data_i   (vid_data_i),
    .wr_lo_o, .wr_hi_o, .pad_o, .wr_data_o
  );

  assign capture_en_o = armed;

  // R8: one bank at a time
  a_r8_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_lo_o && wr_hi_o));

  // R3: a low-half write needs a qualified sample one cycle earlier
  a_r3_lo_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_o |-> $past(dv_i) && $past(capture_en_o));

  // R3: a non-pad high-half write needs a qualified sample too
  a_r3_hi_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_o && !pad_o |-> $past(dv_i) && $past(capture_en_o));

  // R1: software reset silences the outputs
  a_r1_sw_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> fifo_rst_o && !capture_en_o && !wr_lo_o && !wr_hi_o);
endmodule

// File: tb/vid_capture_packer_tb_top.sv
module vid_capture_packer_tb_top;
  localparam int unsigned DW  = 16;
  localparam logic [DW-1:0] PAD = 16'h8010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_rst = 1'b0, dv = 1'b0, vref = 1'b0, field = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] wr_data;
  logic wr_lo, wr_hi, pad, cap_en, fifo_rst;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state, built from the requirements
  bit m_arm = 0, m_sel = 0, m_dvq = 0;

  always #2.5 clk = ~clk;

  vid_capture_packer #(.DATA_W(DW), .FIRST_FIELD(1'b0), .PAD_WORD(PAD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst), .vid_data_i(din),
    .dv_i(dv), .vref_i(vref), .field_i(field),
    .wr_data_o(wr_data), .wr_lo_o(wr_lo), .wr_hi_o(wr_hi), .pad_o(pad),
    .capture_en_o(cap_en), .fifo_rst_o(fifo_rst)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one pixel cycle: drive at negedge, check registered result at the next negedge
  task automatic step(input string tag, input logic i_dv, input logic i_vref,
                      input logic i_field, input logic [DW-1:0] i_d, input logic i_sw);
    bit rise, fall, q, sel, e_lo, e_hi, e_pad, e_fr;
    logic [DW-1:0] e_data;
    e_data = '0;
    if (i_sw) begin
      e_lo = 0; e_hi = 0; e_pad = 0; e_fr = 1;
      m_arm = 0; m_sel = 0; m_dvq = 0;
    end else begin
      e_fr  = 0;
      rise  = i_dv && !m_dvq;
      fall  = !i_dv && m_dvq;
      q     = i_dv && m_arm;
      sel   = rise ? 1'b0 : m_sel;
      e_pad = fall && m_arm && m_sel;
      e_lo  = q && !sel;
      e_hi  = (q && sel) || e_pad;
      e_data = q ? i_d : PAD;
      if (q) m_sel = !sel;
      else if (rise || fall) m_sel = 0;
      if (i_vref && !i_field) m_arm = 1;
      m_dvq = i_dv;
    end
    dv = i_dv; vref = i_vref; field = i_field; din = i_d; sw_rst = i_sw;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "capture_en_o", 32'(cap_en), 32'(m_arm));
    chk(tag, "wr_lo_o", 32'(wr_lo), 32'(e_lo));
    chk(tag, "wr_hi_o", 32'(wr_hi), 32'(e_hi));
    chk(tag, "pad_o", 32'(pad), 32'(e_pad));
    chk("R1", "fifo_rst_o", 32'(fifo_rst), 32'(e_fr));
    chk("R8", "both strobes", 32'(wr_lo && wr_hi), 32'd0);
    if (e_lo || e_hi) chk(tag, "wr_data_o", 32'(wr_data), 32'(e_data));
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, '0, 0);
  endtask

  task automatic line(input string tag, input int len, input int gap);
    for (int i = 0; i < len; i++) step(tag, 1, 0, 0, DW'(len * 256 + i + 1), 0);
    idle(tag, gap);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: state held under reset
    repeat (3) @(negedge clk);
    chk("R1", "fifo_rst_o in reset", 32'(fifo_rst), 32'd1);
    chk("R1", "capture_en_o in reset", 32'(cap_en), 32'd0);
    chk("R1", "strobes in reset", 32'({wr_lo, wr_hi, pad}), 32'd0);
    rst_n = 1'b1;
    idle("R1", 2);

    // R3: active lines before arming are dropped
    line("R3", 4, 2);
    // R2: wrong field does not arm
    step("R2", 0, 1, 1, '0, 0);
    line("R3", 3, 2);
    // R2: first-field vertical reference arms
    step("R2", 0, 1, 0, '0, 0);
    idle("R2", 2);

    // R4 R5 R7: sweep line lengths of both parities
    for (int len = 1; len <= 12; len++) line("R4", len, 2);
    // R5 R7: one-cycle gaps between lines
    line("R5", 3, 1);
    line("R7", 5, 1);
    line("R5", 2, 1);

    // R6: later vertical pulses of either field leave capture armed
    step("R6", 0, 1, 1, '0, 0);
    step("R6", 0, 1, 0, '0, 0);
    line("R6", 5, 2);

    // R1: software reset in mid-line
    step("R1", 1, 0, 0, 16'h0aa1, 0);
    step("R1", 1, 0, 0, 16'h0aa2, 0);
    step("R1", 1, 0, 0, 16'h0aa3, 1);
    step("R1", 1, 0, 0, 16'h0aa4, 0);
    step("R1", 1, 0, 0, 16'h0aa5, 0);
    idle("R1", 2);
    line("R3", 3, 2);
    // R2 R5: re-arm, toggle restarted on the low half
    step("R2", 0, 1, 0, '0, 0);
    line("R5", 3, 2);
    line("R7", 7, 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule